// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block inspects the destination address of an incoming Ethernet frame and decides whether the frame is kept. The six address bytes arrive one per cycle. The first byte is marked by a start strobe. While the bytes arrive, the block compares the address against ten programmable station addresses and computes a CRC over it. The upper CRC bits select one bit of a 64-entry multicast hash table.

One cycle after the sixth byte, the block issues a single-cycle verdict. The verdict gives accept or reject, and it carries three flags:
- whether the destination is a physical (unicast) address,
- whether it is the broadcast address,
- whether a station address matched.

A five-bit mode input selects which acceptance rules apply. A byte-wide configuration write port loads the station addresses and the hash table.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, and in every cycle without a verdict, `verdictValid`, `accept`, `isPhysical`, `isBroadcast` and `addrMatch` are all 0.
- R2: A byte is taken only in a cycle with `byteValid` high, and idle cycles between bytes are allowed. `verdictValid` is high for exactly the one cycle that follows the cycle in which the sixth byte of a frame is taken.
- R3: Station 0 is always compared. When the destination equals it, `addrMatch` is 1 and the frame is accepted.
- R4: Station k (0..9) holds its byte j (0..5) at configuration address 6*k+j, where byte 0 is the first received byte. Stations 1..9 take part in the comparison only when mode bit 0 is 1.
- R5: A frame that is not broadcast and has bit 0 of its first byte equal to 0 is physical. If it matches no station, it is accepted only when mode bit 2 (promiscuous) is 1.
- R6: A frame that is not broadcast and has bit 0 of its first byte equal to 1 is accepted when mode bit 1 (all multicast) is 1.
- R7: With mode bit 4 set, a non-broadcast multicast frame is also accepted when its hash bit is 1. The hash is computed as follows:
  - Start a CRC register at 0xFFFFFFFF.
  - Process the bits of byte 0 to byte 5, least significant bit first.
  - At each step, XOR CRC[31] with the input bit. Shift the register left by one. If the XOR result was 1, XOR the register with 0x04C11DB7.
  - The hash index bit i equals the final CRC[31-i], for i = 0..5.
  - Table bit n is stored in bit n%8 of the byte at configuration address 64+n/8.
- R8: An all-ones destination sets `isBroadcast`. It is accepted when mode bit 3 is 0 and rejected when mode bit 3 is 1.
- R9: `isPhysical` equals the inverse of bit 0 of the first byte. `isPhysical` is 0 for a broadcast.
- R10: A start strobe that arrives with a byte while a frame is in progress aborts that frame. No verdict is issued for the aborted frame, and the new byte becomes byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeBits | input | 5 | bit0 station 1..9 enable, bit1 all multicast, bit2 promiscuous, bit3 reject broadcast, bit4 hash enable |
| byteValid | input | 1 | `byteIn` carries an address byte this cycle |
| frameStart | input | 1 | With `byteValid`, marks byte 0 of a frame |
| byteIn | input | 8 | Destination address byte |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 7 | Configuration byte address (0..59 stations, 64..71 hash table) |
| cfgData | input | 8 | Configuration write data |
| verdictValid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame accepted |
| isPhysical | output | 1 | Destination is physical (unicast) |
| isBroadcast | output | 1 | Destination is all ones |
| addrMatch | output | 1 | An enabled station address matched |

## Verification
The filter is exercised with four kinds of destination, each under many mode settings:
- Addresses copied from the programmed stations separate the always-on station 0 from the enable-gated stations 1..9.
- Random unicast addresses isolate the promiscuous rule.
- Random multicast addresses, with the hash table set to all ones, to all zeros and to random contents, show the hash index and its bit reversal.
- The broadcast address checks the reject-broadcast bit.

Directed runs add idle gaps between bytes and a start strobe in the middle of a frame, which separate correct byte counting from counting cycles.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int BYTE_IDX_W = 3;
  localparam int MODE_W = 5;
  localparam int MODE_IA_EN = 0;
  localparam int MODE_ALL_MC = 1;
  localparam int MODE_PROMISC = 2;
  localparam int MODE_NO_BCAST = 3;
  localparam int MODE_HASH_EN = 4;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef struct packed {
    logic shiftByte;
    logic firstByte;
    logic finish;
    logic [BYTE_IDX_W-1:0] byteIdx;
  } ctrlStrobesT;

  function automatic logic [31:0] crcStepByte(input logic [31:0] crcIn, input logic [7:0] data);
    logic [31:0] c;
    logic fb;
    c = crcIn;
    for (int k = 0; k < 8; k++) begin
      fb = c[31] ^ data[k];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxaf_ctrl.sv
module rxaf_ctrl
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        frameStart,
  output ctrlStrobesT strobes
);
  logic active;
  logic [BYTE_IDX_W-1:0] cnt;

  always_comb begin
    strobes.firstByte = byteValid && frameStart;
    strobes.shiftByte = byteValid && (frameStart || active);
    strobes.byteIdx   = frameStart ? '0 : cnt;
    strobes.finish    = strobes.shiftByte &&
                        (strobes.byteIdx == BYTE_IDX_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (strobes.shiftByte) begin
      if (strobes.finish) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        active <= 1'b1;
        cnt    <= strobes.byteIdx + BYTE_IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/rxaf_datapath.sv
module rxaf_datapath
  import rxaf_pkg::*;
#(
  parameter int NUM_STATIONS = 10,
  parameter int HASH_BITS    = 64,
  parameter int CFG_AW       = 7,
  parameter int HASH_BASE    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [MODE_W-1:0] modeBits,
  input  logic [7:0]        byteIn,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgData,
  output logic              verdictValid,
  output logic              accept,
  output logic              isPhysical,
  output logic              isBroadcast,
  output logic              addrMatch
);
  localparam int SLOTS      = NUM_STATIONS * ADDR_BYTES;
  localparam int DA_W       = 8 * ADDR_BYTES;
  localparam int HASH_BYTES = HASH_BITS / 8;
  localparam int IDX_W      = $clog2(HASH_BITS);

  logic [7:0] slotMem [SLOTS];
  logic [HASH_BITS-1:0] hashTable;
  logic [DA_W-1:0] daReg, daNext;
  logic [31:0] crcReg, crcNext;

  // configuration storage
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotMem[s] <= '0;
      else if (cfgWe && cfgAddr == CFG_AW'(s)) slotMem[s] <= cfgData;
    end
  end

  for (genvar b = 0; b < HASH_BYTES; b++) begin : g_hash
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hashTable[8*b +: 8] <= '0;
      else if (cfgWe && cfgAddr == CFG_AW'(HASH_BASE + b)) hashTable[8*b +: 8] <= cfgData;
    end
  end

  // address capture and running CRC
  always_comb begin
    daNext = daReg;
    for (int j = 0; j < ADDR_BYTES; j++)
      if (strobes.shiftByte && strobes.byteIdx == BYTE_IDX_W'(j)) daNext[8*j +: 8] = byteIn;
    crcNext = crcReg;
    if (strobes.shiftByte)
      crcNext = crcStepByte(strobes.firstByte ? 32'hFFFF_FFFF : crcReg, byteIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      daReg  <= '0;
      crcReg <= 32'hFFFF_FFFF;
    end else begin
      daReg  <= daNext;
      crcReg <= crcNext;
    end
  end

  // station comparison
  logic [NUM_STATIONS-1:0] stationHit;
  for (genvar k = 0; k < NUM_STATIONS; k++) begin : g_cmp
    logic [DA_W-1:0] stationVal;
    always_comb begin
      for (int j = 0; j < ADDR_BYTES; j++) stationVal[8*j +: 8] = slotMem[k*ADDR_BYTES + j];
    end
    if (k == 0) begin : g_always
      assign stationHit[k] = (daNext == stationVal);
    end else begin : g_gated
      assign stationHit[k] = modeBits[MODE_IA_EN] && (daNext == stationVal);
    end
  end

  // hash lookup with reversed top CRC bits
  logic [IDX_W-1:0] hashIdx;
  always_comb begin
    for (int i = 0; i < IDX_W; i++) hashIdx[i] = crcNext[31-i];
  end

  logic mcNext, bcNext, matchNext, acceptNext;
  always_comb begin
    mcNext    = daNext[0];
    bcNext    = &daNext;
    matchNext = |stationHit;
    if (bcNext)
      acceptNext = !modeBits[MODE_NO_BCAST];
    else if (mcNext)
      acceptNext = modeBits[MODE_ALL_MC] || matchNext ||
                   (modeBits[MODE_HASH_EN] && hashTable[hashIdx]);
    else
      acceptNext = modeBits[MODE_PROMISC] || matchNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verdictValid <= 1'b0;
      accept       <= 1'b0;
      isPhysical   <= 1'b0;
      isBroadcast  <= 1'b0;
      addrMatch    <= 1'b0;
    end else begin
      verdictValid <= strobes.finish;
      accept       <= strobes.finish && acceptNext;
      isPhysical   <= strobes.finish && !mcNext;
      isBroadcast  <= strobes.finish && bcNext;
      addrMatch    <= strobes.finish && matchNext;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int NUM_STATIONS = 10,
  parameter int HASH_BITS    = 64,
  parameter int CFG_AW       = 7,
  parameter int HASH_BASE    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeBits,
  input  logic              byteValid,
  input  logic              frameStart,
  input  logic [7:0]        byteIn,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgData,
  output logic              verdictValid,
  output logic              accept,
  output logic              isPhysical,
  output logic              isBroadcast,
  output logic              addrMatch
);
  ctrlStrobesT strobes;

  rxaf_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameStart(frameStart), .strobes(strobes)
  );

  rxaf_datapath #(
    .NUM_STATIONS(NUM_STATIONS), .HASH_BITS(HASH_BITS), .CFG_AW(CFG_AW), .HASH_BASE(HASH_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeBits(modeBits), .byteIn(byteIn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .verdictValid(verdictValid), .accept(accept), .isPhysical(isPhysical),
    .isBroadcast(isBroadcast), .addrMatch(addrMatch)
  );
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker
  import rxaf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] modeBits,
  input logic              byteValid,
  input logic              verdictValid,
  input logic              accept,
  input logic              isPhysical,
  input logic              isBroadcast,
  input logic              addrMatch
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |=> !verdictValid);

  a_r2_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> $past(byteValid));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !verdictValid |-> !(accept || isPhysical || isBroadcast || addrMatch));

  a_r8_bcast_reject: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && isBroadcast && $past(modeBits[MODE_NO_BCAST])) |-> !accept);

  a_r9_bcast_not_phys: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && isBroadcast) |-> !isPhysical);

  a_r5_phys_needs_rule: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && isPhysical && !addrMatch && !$past(modeBits[MODE_PROMISC])) |-> !accept);

  a_r3_match_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && isPhysical && addrMatch) |-> accept);
endmodule

bind rx_addr_filter rxaf_checker chk_i (.*);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] modeBits = '0;
  logic byteValid = 1'b0, frameStart = 1'b0;
  logic [7:0] byteIn = '0;
  logic cfgWe = 1'b0;
  logic [6:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic verdictValid, accept, isPhysical, isBroadcast, addrMatch;

  int tests = 0, fails = 0;
  logic [47:0] st [10];
  logic [63:0] hashM;

  always #10 clk = ~clk;

  rx_addr_filter dut_i (.*);

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic checkEq(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] hashIdxOf(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    logic [5:0] idx;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ da[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    for (int j = 0; j < 6; j++) idx[j] = c[31-j];
    return idx;
  endfunction

  function automatic logic expMatch(input logic [47:0] da);
    logic m = (da == st[0]);
    for (int k = 1; k < 10; k++) if (modeBits[0] && da == st[k]) m = 1'b1;
    return m;
  endfunction

  function automatic logic expAccept(input logic [47:0] da);
    if (&da) return !modeBits[3];
    if (da[0]) return modeBits[1] || expMatch(da) || (modeBits[4] && hashM[hashIdxOf(da)]);
    return modeBits[2] || expMatch(da);
  endfunction

  task automatic cfgWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 7'(a); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic loadHash(input logic [63:0] h);
    hashM = h;
    for (int b = 0; b < 8; b++) cfgWrite(64 + b, h[8*b +: 8]);
  endtask

  task automatic runFrame(input logic [47:0] da, input int gap, input string tag);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      checkEq({tag, " R2 no early verdict"}, verdictValid, 0);
      byteValid = 1'b1; frameStart = (i == 0); byteIn = da[8*i +: 8];
      for (int g = 0; g < gap && i < 5; g++) begin
        @(negedge clk);
        byteValid = 1'b0; frameStart = 1'b0; byteIn = 8'hA5;
        checkEq({tag, " R2 gap quiet"}, verdictValid, 0);
      end
    end
    @(negedge clk);
    byteValid = 1'b0; frameStart = 1'b0;
    checkEq({tag, " R2 verdict valid"}, verdictValid, 1);
    checkEq({tag, " accept"}, accept, expAccept(da));
    checkEq({tag, " R9 physical"}, isPhysical, !da[0]);
    checkEq({tag, " R8 broadcast"}, isBroadcast, &da);
    checkEq({tag, " R3 R4 match"}, addrMatch, expMatch(da));
    @(negedge clk);
    checkEq({tag, " R2 single pulse"}, verdictValid, 0);
    checkEq({tag, " R1 quiet accept"}, accept, 0);
  endtask

  function automatic logic [47:0] rndAddr(input logic mc);
    logic [47:0] a = {$urandom, $urandom};
    a[0] = mc;
    return a;
  endfunction

  initial begin
    logic [47:0] da;
    int unused;
    unused = $urandom(32'h1357);
    repeat (3) @(negedge clk);
    checkEq("R1 reset valid", verdictValid, 0);
    checkEq("R1 reset accept", accept, 0);
    rstN = 1'b1;
    for (int k = 0; k < 10; k++) begin
      st[k] = rndAddr(1'b0);
      for (int j = 0; j < 6; j++) cfgWrite(6*k + j, st[k][8*j +: 8]);
    end
    loadHash('0);

    modeBits = 5'b00000;
    runFrame(st[0], 0, "R3 station0");
    runFrame(st[4], 0, "R4 station4 disabled");
    modeBits = 5'b00001;
    runFrame(st[9], 0, "R4 station9 enabled");
    runFrame(rndAddr(1'b0), 0, "R5 unicast no promisc");
    modeBits = 5'b00100;
    runFrame(rndAddr(1'b0), 0, "R5 unicast promisc");
    modeBits = 5'b00000;
    runFrame(rndAddr(1'b1), 0, "R6 mc rejected");
    modeBits = 5'b00010;
    runFrame(rndAddr(1'b1), 0, "R6 all multicast");
    modeBits = 5'b10000;
    loadHash('1);
    runFrame(rndAddr(1'b1), 0, "R7 hash all ones");
    loadHash('0);
    runFrame(rndAddr(1'b1), 0, "R7 hash all zeros");
    for (int n = 0; n < 6; n++) begin
      da = rndAddr(1'b1);
      loadHash(64'd1 << hashIdxOf(da));
      runFrame(da, 0, "R7 single hash bit");
    end
    loadHash({$urandom, $urandom});
    modeBits = 5'b00000;
    runFrame('1, 0, "R8 bcast accepted");
    modeBits = 5'b01110;
    runFrame('1, 0, "R8 bcast rejected");
    modeBits = 5'b00001;
    runFrame(st[2], 3, "R2 gapped frame");

    // R10: abort after three bytes
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byteValid = 1'b1; frameStart = (i == 0); byteIn = 8'hFF;
    end
    runFrame(st[5], 0, "R10 restart");
    // R10: start strobe on what would be the sixth byte
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      byteValid = 1'b1; frameStart = (i == 0); byteIn = st[1][8*i +: 8];
    end
    runFrame(rndAddr(1'b0), 1, "R10 late restart");

    for (int n = 0; n < 250; n++) begin
      int pick = $urandom_range(0, 9);
      modeBits = 5'($urandom);
      if (pick < 3) da = st[$urandom_range(0, 9)];
      else if (pick == 3) da = '1;
      else da = rndAddr(pick > 6);
      runFrame(da, $urandom_range(0, 2), "R3 R4 R5 R6 R7 R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule